// File: doc/BRIEF.md
# Float Round-and-Pack Unit

This unit is the last stage of a single-precision floating-point datapath. It accepts an intermediate result made of a sign, a signed 10-bit biased exponent and a 32-bit significand that carries 7 guard bits below the final fraction. It then rounds the result under one of four run-time rounding modes and packs it into a 32-bit IEEE 754 word. Results too large for the format saturate to infinity or to the largest finite value, depending on the rounding direction. Results below the normal range are shifted right into subnormal form, with a sticky bit collecting the shifted-out bits.

The significand's binary point lies between bits 30 and 29. An input with bit 30 set is normalized, and then the given exponent is one less than the exponent field that is packed. An optional leading-zero stage first shifts a short significand left until bit 30 is set, and lowers the exponent by the same amount. Each accepted operation updates a registered result. Overflow, underflow and inexact flags build up across operations until a synchronous clear is applied.

Top module: `rp_round_pack`

## Requirements
- R1: After reset, `res_word` is 0 and all three flag outputs are 0.
- R2: `rnd_mode` encodes 0 = nearest-even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. The rounding increment added to the significand is 0x40 for nearest-even and 0 for toward-zero. For a directed mode it is 0x7F when the mode rounds away from zero for the input sign (mode 1 with sign 1, mode 2 with sign 0), and 0 otherwise.
- R3: With a non-negative exponent and no overflow, the output fraction is (significand + increment) >> 7. The word is sign<<31 + exponent<<23 + fraction, summed so that a carry out of the fraction raises the exponent field. Inexact is flagged when the low 7 guard bits are nonzero.
- R4: Overflow happens when the exponent exceeds 0xFD, or equals 0xFD and significand + increment (32-bit) has bit 31 set. Overflow raises the overflow and inexact flags. The result is signed infinity if the increment is nonzero, and otherwise the signed largest finite value (magnitude 0x7F7FFFFF).
- R5: `res_word` and the flags change only on a clock edge where `op_valid` is 1. The result appears on the edge that samples the operation.
- R6: Underflow is raised only when the exponent is negative, the result is tiny and the guard bits after denormalization are nonzero. Tiny means `tiny_before` = 1, or exponent < -1, or significand + increment < 0x80000000.
- R7: A negative exponent shifts the significand right by its magnitude. The OR of the shifted-out bits is merged into bit 0, a shift of 32 or more leaves only that sticky bit, and the exponent becomes 0.
- R8: In nearest-even mode, when the guard bits are exactly 0x40 (a tie), bit 0 of the rounded fraction is cleared. A rounded fraction of zero forces the exponent field to 0.
- R9: The flags OR in each accepted operation's flags. `flag_clr` clears them on the next edge, and when `flag_clr` and `op_valid` are both 1 the flags take exactly the new operation's flags.
- R10: With `norm_en` = 1 the significand is first shifted left by (leading zeros − 1) and the exponent lowered by that amount. A significand with bit 31 set is not shifted, and a zero significand lowers the exponent by 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operands this cycle |
| flag_clr | input | 1 | Synchronous clear of the accumulated flags |
| in_sign | input | 1 | Result sign |
| in_exp | input | 10 | Signed biased exponent |
| in_sig | input | 32 | Significand, point between bits 30 and 29, 7 guard bits |
| rnd_mode | input | 2 | Rounding mode (R2) |
| tiny_before | input | 1 | 1 = detect tininess before rounding |
| norm_en | input | 1 | 1 = normalize by leading-zero count first |
| res_word | output | 32 | Packed single-precision result |
| flag_ovf | output | 1 | Accumulated overflow |
| flag_unf | output | 1 | Accumulated underflow |
| flag_inx | output | 1 | Accumulated inexact |

## Verification
The bench uses the defaults: a 32-bit significand, 7 guard bits, a 10-bit exponent, an 8-bit exponent field and the normalizer present. These widths put the 0xFD overflow boundary and the carry into bit 31 directly in reach. They also allow shift distances from 1 up to beyond 32, so the sticky-only case is reachable. Because the leading-zero stage is built in, the bench can switch between the raw path and the normalize-first path from one operation to the next.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } rp_flags_t;
endpackage

// File: rtl/rp_normalize.sv
module rp_normalize #(
  parameter int SIG_W = 32,
  parameter int EXP_W = 10
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  localparam int CNT_W = $clog2(SIG_W) + 1;

  function automatic logic [CNT_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
    logic [CNT_W-1:0] n;
    logic             seen;
    n = '0;
    seen = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  logic [CNT_W-1:0] lz;
  logic [CNT_W-1:0] shamt;

  always_comb begin
    lz    = lead_zeros(sig_i);
    shamt = (lz == '0) ? '0 : lz - 1'b1;
    sig_o = sig_i << shamt;
    exp_o = exp_i - $signed(EXP_W'(shamt));
  end
endmodule

// File: rtl/rp_round_core.sv
module rp_round_core #(
  parameter int SIG_W   = 32,
  parameter int EXP_W   = 10,
  parameter int GUARD_W = 7,
  parameter int FEXP_W  = 8
) (
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic [1:0]              mode_i,
  input  logic                    tiny_before_i,
  output logic [SIG_W-1:0]        word_o,
  output rp_pkg::rp_flags_t       flags_o
);
  import rp_pkg::*;

  localparam int OUT_W  = SIG_W - GUARD_W;
  localparam int FRAC_W = OUT_W - 2;
  localparam logic signed [EXP_W-1:0] MAX_BE = EXP_W'((1 << FEXP_W) - 3);
  localparam logic signed [EXP_W-1:0] NEG1   = -1;
  localparam logic [SIG_W-1:0] TOP_BIT = SIG_W'(1) << (SIG_W - 1);
  localparam logic [GUARD_W-1:0] HALF  = GUARD_W'(1) << (GUARD_W - 1);

  function automatic logic [SIG_W-1:0] round_inc(input rmode_e m, input logic s);
    logic [GUARD_W-1:0] g;
    case (m)
      RM_NEAR: g = HALF;
      RM_DOWN: g = s ? '1 : '0;
      RM_UP:   g = s ? '0 : '1;
      default: g = '0;
    endcase
    return SIG_W'(g);
  endfunction

  function automatic logic [SIG_W-1:0] shr_sticky(input logic [SIG_W-1:0] v,
                                                   input logic [EXP_W-1:0] amt);
    logic [SIG_W-1:0] mask;
    if (amt >= EXP_W'(SIG_W)) return SIG_W'(v != '0);
    mask = ~({SIG_W{1'b1}} << amt);
    return (v >> amt) | SIG_W'((v & mask) != '0);
  endfunction

  rmode_e                  mode;
  logic [SIG_W-1:0]        inc;
  logic [SIG_W-1:0]        sum_in;
  logic                    big;
  logic                    neg;
  logic                    tiny;
  logic [SIG_W-1:0]        sig_d;
  logic signed [EXP_W-1:0] e_d;
  logic [GUARD_W-1:0]      guard;
  logic [SIG_W-1:0]        sum_d;
  logic [OUT_W-1:0]        sig_r;
  logic signed [EXP_W-1:0] e_r;

  always_comb begin
    mode   = rmode_e'(mode_i);
    inc    = round_inc(mode, sign_i);
    sum_in = sig_i + inc;
    big    = (exp_i > MAX_BE) || ((exp_i == MAX_BE) && (sum_in >= TOP_BIT));
    neg    = exp_i < 0;
    tiny   = tiny_before_i || (exp_i < NEG1) || (sum_in < TOP_BIT);
    sig_d  = neg ? shr_sticky(sig_i, EXP_W'(-exp_i)) : sig_i;
    e_d    = neg ? '0 : exp_i;
    guard  = sig_d[GUARD_W-1:0];
    sum_d  = sig_d + inc;
    sig_r  = OUT_W'(sum_d >> GUARD_W);
    if ((mode == RM_NEAR) && (guard == HALF)) sig_r[0] = 1'b0;
    e_r    = (sig_r == '0) ? '0 : e_d;
    if (big) begin
      word_o  = {sign_i, {FEXP_W{1'b1}}, {FRAC_W{1'b0}}} - SIG_W'(inc == '0);
      flags_o = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
    end else begin
      word_o  = {sign_i, {(SIG_W-1){1'b0}}}
              + (SIG_W'($unsigned(e_r)) << FRAC_W)
              + SIG_W'(sig_r);
      flags_o = '{ovf: 1'b0, unf: neg && tiny && (guard != '0), inx: guard != '0};
    end
  end
endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack #(
  parameter int SIG_W    = 32,
  parameter int EXP_W    = 10,
  parameter int GUARD_W  = 7,
  parameter int FEXP_W   = 8,
  parameter bit HAS_NORM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              flag_clr,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic [1:0]        rnd_mode,
  input  logic              tiny_before,
  input  logic              norm_en,
  output logic [SIG_W-1:0]  res_word,
  output logic              flag_ovf,
  output logic              flag_unf,
  output logic              flag_inx
);
  import rp_pkg::*;

  localparam logic [SIG_W-1:0] MAX_FIN = {1'b0, {(FEXP_W-1){1'b1}}, 1'b0, {(SIG_W-FEXP_W-1){1'b1}}};

  logic signed [EXP_W-1:0] sel_exp;
  logic [SIG_W-1:0]        sel_sig;
  logic [SIG_W-1:0]        core_word;
  rp_flags_t               core_flags;
  rp_flags_t               acc;

  generate
    if (HAS_NORM) begin : g_norm
      logic signed [EXP_W-1:0] n_exp;
      logic [SIG_W-1:0]        n_sig;
      rp_normalize #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
        .exp_i(EXP_W'(in_exp)), .sig_i(in_sig), .exp_o(n_exp), .sig_o(n_sig)
      );
      assign sel_exp = norm_en ? n_exp : $signed(in_exp);
      assign sel_sig = norm_en ? n_sig : in_sig;
    end else begin : g_raw
      logic unused_norm;
      assign unused_norm = norm_en;
      assign sel_exp = $signed(in_exp);
      assign sel_sig = in_sig;
    end
  endgenerate

  rp_round_core #(.SIG_W(SIG_W), .EXP_W(EXP_W), .GUARD_W(GUARD_W), .FEXP_W(FEXP_W)) u_core (
    .sign_i(in_sign), .exp_i(sel_exp), .sig_i(sel_sig), .mode_i(rnd_mode),
    .tiny_before_i(tiny_before), .word_o(core_word), .flags_o(core_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_word <= '0;
      acc      <= '0;
    end else begin
      if (op_valid) res_word <= core_word;
      if (flag_clr) acc <= op_valid ? core_flags : '0;
      else if (op_valid) acc <= acc | core_flags;
    end
  end

  assign flag_ovf = acc.ovf;
  assign flag_unf = acc.unf;
  assign flag_inx = acc.inx;

  // R4: an accepted overflow yields infinity or the largest finite magnitude
  a_r4_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && core_flags.ovf) |=>
      (res_word[SIG_W-2:SIG_W-FEXP_W-1] == {FEXP_W{1'b1}}) || (res_word[SIG_W-2:0] == MAX_FIN[SIG_W-2:0]));

  // R6: underflow is never reported without inexact
  a_r6_unf_needs_inx: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && core_flags.unf) |-> core_flags.inx);

  // R5: result holds when no operation is accepted
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_word));

  // R9: flags stay set until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_inx && !flag_clr) |=> flag_inx);

  // R9: a clear without an operation empties all flags
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !op_valid) |=> (!flag_ovf && !flag_unf && !flag_inx));
endmodule

// File: tb/rp_round_pack_test.sv
`timescale 1ns/1ps
module rp_round_pack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        flag_clr = 1'b0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  rnd_mode = '0;
  logic        tiny_before = 1'b0;
  logic        norm_en = 1'b0;
  logic [31:0] res_word;
  logic        flag_ovf, flag_unf, flag_inx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rp_round_pack uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .flag_clr(flag_clr),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode),
    .tiny_before(tiny_before), .norm_en(norm_en), .res_word(res_word),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx)
  );

  // independent model: returns {ovf, unf, inx, word}
  function automatic logic [34:0] model(input bit s, input int e, input longint unsigned m,
                                        input int mode, input bit tb, input bit nrm);
    longint unsigned inc, sum, g, q;
    bit away, o, u, x;
    longint unsigned w;
    if (nrm) begin
      if (m == 0) e = e - 31;
      else while (m < 64'h4000_0000) begin m = m << 1; e = e - 1; end
    end
    away = (mode == 2 && !s) || (mode == 1 && s);
    inc  = (mode == 0) ? 64'h40 : (away ? 64'h7F : 64'h0);
    sum  = (m + inc) & 64'hFFFF_FFFF;
    if (e > 253 || (e == 253 && sum >= 64'h8000_0000)) begin
      w = (inc != 0) ? 64'h7F80_0000 : 64'h7F7F_FFFF;
      if (s) w = w | 64'h8000_0000;
      return {3'b101, w[31:0]};
    end
    u = 1'b0;
    if (e < 0) begin
      bit t;
      t = tb || (e < -1) || (sum < 64'h8000_0000);
      if (-e >= 32) m = (m != 0) ? 1 : 0;
      else m = (m >> (-e)) | (((m & ((64'd1 << (-e)) - 1)) != 0) ? 1 : 0);
      e = 0;
      u = t && ((m & 64'h7F) != 0);
    end
    g = m & 64'h7F;
    x = (g != 0);
    q = ((m + inc) & 64'hFFFF_FFFF) / 128;
    if (mode == 0 && g == 64'h40) q = q & ~64'd1;
    if (q == 0) e = 0;
    w = ((s ? 64'h8000_0000 : 64'd0) + (longint'(e) * 64'h80_0000) + q) & 64'hFFFF_FFFF;
    o = 1'b0;
    return {o, u, x, w[31:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one isolated operation: flags cleared and replaced by this op's flags
  task automatic run_op(input bit s, input int e, input logic [31:0] m, input int mode,
                        input bit tb, input bit nrm);
    @(negedge clk);
    in_sign = s; in_exp = 10'(e); in_sig = m; rnd_mode = 2'(mode);
    tiny_before = tb; norm_en = nrm; op_valid = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic op_check(input string req, input bit s, input int e, input logic [31:0] m,
                          input int mode, input bit tb, input bit nrm,
                          input logic [31:0] ew, input logic [2:0] ef);
    logic [34:0] r;
    r = model(s, e, m, mode, tb, nrm);
    run_op(s, e, m, mode, tb, nrm);
    chk(req, res_word, ew);
    chk(req, {29'd0, flag_ovf, flag_unf, flag_inx}, {29'd0, ef});
    chk({req, " model"}, res_word, r[31:0]);
  endtask

  task automatic t_reset;
    chk("R1 result", res_word, 32'h0);
    chk("R1 flags", {29'd0, flag_ovf, flag_unf, flag_inx}, 32'h0);
  endtask

  task automatic t_basic;
    op_check("R3 one", 0, 126, 32'h4000_0000, 0, 0, 0, 32'h3F80_0000, 3'b000);
    op_check("R3 carry to exponent", 0, 126, 32'h7FFF_FFC0, 0, 0, 0, 32'h4000_0000, 3'b001);
    op_check("R2 up positive", 0, 126, 32'h4000_0001, 2, 0, 0, 32'h3F80_0001, 3'b001);
    op_check("R2 up negative", 1, 126, 32'h4000_0001, 2, 0, 0, 32'hBF80_0000, 3'b001);
    op_check("R2 down negative", 1, 126, 32'h4000_0001, 1, 0, 0, 32'hBF80_0001, 3'b001);
    op_check("R2 toward zero", 0, 126, 32'h4000_007F, 3, 0, 0, 32'h3F80_0000, 3'b001);
  endtask

  task automatic t_overflow;
    op_check("R4 inf nearest", 0, 254, 32'h4000_0000, 0, 0, 0, 32'h7F80_0000, 3'b101);
    op_check("R4 max toward zero", 0, 254, 32'h4000_0000, 3, 0, 0, 32'h7F7F_FFFF, 3'b101);
    op_check("R4 max down positive", 0, 300, 32'h4000_0000, 1, 0, 0, 32'h7F7F_FFFF, 3'b101);
    op_check("R4 inf down negative", 1, 254, 32'h4000_0000, 1, 0, 0, 32'hFF80_0000, 3'b101);
    op_check("R4 FD carry", 0, 253, 32'h7FFF_FFC0, 0, 0, 0, 32'h7F80_0000, 3'b101);
    op_check("R4 FD no carry", 0, 253, 32'h7FFF_FFC0, 3, 0, 0, 32'h7F7F_FFFF, 3'b001);
  endtask

  task automatic t_tie;
    op_check("R8 tie to even down", 0, 126, 32'h4000_0040, 0, 0, 0, 32'h3F80_0000, 3'b001);
    op_check("R8 tie to even up", 0, 126, 32'h4000_00C0, 0, 0, 0, 32'h3F80_0002, 3'b001);
    op_check("R8 zero forces exponent", 0, 126, 32'h0000_0000, 0, 0, 0, 32'h0000_0000, 3'b000);
  endtask

  task automatic t_subnormal;
    op_check("R7 shift by one exact", 0, -1, 32'h4000_0000, 0, 0, 0, 32'h0040_0000, 3'b000);
    op_check("R7 sticky only nearest", 0, -100, 32'h4000_0000, 0, 0, 0, 32'h0000_0000, 3'b011);
    op_check("R7 sticky only up", 0, -100, 32'h4000_0000, 2, 0, 0, 32'h0000_0001, 3'b011);
  endtask

  task automatic t_tiny_mode;
    op_check("R6 after not tiny", 0, -1, 32'h7FFF_FFC0, 0, 0, 0, 32'h0080_0000, 3'b001);
    op_check("R6 before tiny", 0, -1, 32'h7FFF_FFC0, 0, 1, 0, 32'h0080_0000, 3'b011);
  endtask

  task automatic t_normalize;
    op_check("R10 shift left", 0, 136, 32'h0010_0000, 0, 0, 1, 32'h3F80_0000, 3'b000);
    op_check("R10 top bit set", 0, 126, 32'h8000_0000, 3, 0, 1, 32'h3F80_0000 + 32'h0080_0000, 3'b000);
    op_check("R10 zero input", 0, 126, 32'h0, 0, 0, 1, 32'h0, 3'b000);
  endtask

  task automatic t_flags;
    run_op(0, 254, 32'h4000_0000, 0, 0, 0);
    @(negedge clk);
    in_exp = 10'd126; in_sig = 32'h4000_0000; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 flags accumulate", {29'd0, flag_ovf, flag_unf, flag_inx}, 32'h5);
    chk("R5 new result", res_word, 32'h3F80_0000);
    in_exp = 10'd254;
    @(negedge clk);
    chk("R5 hold without op", res_word, 32'h3F80_0000);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 clear", {29'd0, flag_ovf, flag_unf, flag_inx}, 32'h0);
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'hACE1_2345;
    logic [34:0] r;
    for (int i = 0; i < 300; i++) begin
      int e;
      bit s;
      int mode;
      bit tb, nrm;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      s = lf[3]; mode = int'(lf[5:4]); tb = lf[6]; nrm = lf[7];
      e = int'(lf[16:8]) - 60;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      r = model(s, e, {1'b0, lf[30:0]}, mode, tb, nrm);
      run_op(s, e, {1'b0, lf[30:0]}, mode, tb, nrm);
      chk("R3 sweep word", res_word, r[31:0]);
      chk("R6 sweep flags", {29'd0, flag_ovf, flag_unf, flag_inx}, {29'd0, r[34:32]});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overflow();
    t_tie();
    t_subnormal();
    t_tiny_mode();
    t_normalize();
    t_flags();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule